// File: doc/BRIEF.md
# Flash Program Clock Divider

This block derives the slow timing strobe that paces flash program and erase pulses from the fast system clock. Software loads one control byte holding a prescale select and a six-bit divide value. The block then emits a one-cycle enable pulse, `tick`, once every `(1 + 7*pre) * (div + 1)` system clocks. With `pre` set, the clock is first divided by eight; with `pre` clear, that stage is bypassed. For example, a control value of 0x54 at 33 MHz divides by 8 and then by 21, which gives roughly 196.4 kHz.

A sticky flag records that the control byte has been written since reset. Program and erase commands are only permitted once that flag is set, and the strobe stays silent until then. Rewriting the control byte restarts both counting stages from zero. Given the system clock frequency as a parameter, the block also reports whether the resulting strobe rate lies outside the safe 150 kHz to 200 kHz window.

Top module: `flash_tick_gen`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `loaded`, `tick`, `cmd_permit` and `freq_out_of_range` are all 0.
- R2: A write captures `wr_data[6]` as the prescale select and `wr_data[5:0]` as the divide value. `rd_data` returns `{loaded, pre, div}` with `loaded` in bit 7. The value written to bit 7 is ignored.
- R3: Any write sets `loaded` at the next clock edge, and `loaded` then stays at 1 until the next reset.
- R4: `cmd_permit` is 1 exactly when `loaded` is 1. While `loaded` is 0, `tick` stays at 0.
- R5: Once loaded and not rewritten, `tick` is a single-cycle pulse that repeats every N = (pre ? 8 : 1) * (div + 1) clock cycles.
- R6: With the prescale select at 0, the period is div + 1. With div = 0 as well, `tick` is high on every cycle.
- R7: A write restarts counting. `tick` is first high in the cycle that ends N clock edges after the write's edge, and in no earlier cycle.
- R8: `freq_out_of_range` is 1 when `loaded` is 1 and floor(SYS_CLK_HZ / N) is below 150000 or above 200000. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write (bit 6 prescale select, bits 5:0 divide value) |
| rd_data | output | 8 | Readback: bit 7 loaded flag, bit 6 prescale select, bits 5:0 divide value |
| tick | output | 1 | One-cycle timing enable pulse |
| loaded | output | 1 | Control byte written since reset |
| cmd_permit | output | 1 | Program and erase commands allowed |
| freq_out_of_range | output | 1 | Strobe rate outside the 150 kHz to 200 kHz window |

## Verification
The bench aims at the rewrite-mid-period case. A design that kept its old count would fire early after the second write instead of a full period later. It also covers the bypass with a zero divide value, where a design that forced at least one idle cycle would drop pulses. Writing bit 7 as 0 after loading would expose a flag that could be cleared by software. The window edges are probed from both sides: divide values 26 and 27 with the prescaler, and 0x54 against the same divide without the prescaler. This catches a swapped comparison or a period that is off by one. A reset mid-run checks that the strobe and the permit fall silent together.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;

  typedef logic [63:0] u64_t;

  // Number of system clocks between two timing strobes.
  function automatic u64_t strobe_period(input logic pre_en, input u64_t div_val,
                                         input u64_t pre_ratio);
    u64_t stage1;
    stage1 = pre_en ? pre_ratio : 64'd1;
    return stage1 * (div_val + 64'd1);
  endfunction

  // floor(sys/period) < lo  <=>  sys < lo*period
  // floor(sys/period) > hi  <=>  sys >= (hi+1)*period
  function automatic logic outside_window(input u64_t sys_hz, input u64_t period,
                                          input u64_t lo_hz, input u64_t hi_hz);
    logic too_slow;
    logic too_fast;
    too_slow = sys_hz < (lo_hz * period);
    too_fast = sys_hz >= ((hi_hz + 64'd1) * period);
    return too_slow | too_fast;
  endfunction

endpackage

// File: rtl/flash_tick_cfg_reg.sv
module flash_tick_cfg_reg #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_pre,
  input  logic [DIV_W-1:0] wr_div,
  output logic             pre_en,
  output logic [DIV_W-1:0] div_val,
  output logic             loaded
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en  <= 1'b0;
      div_val <= '0;
      loaded  <= 1'b0;
    end else if (wr_en) begin
      pre_en  <= wr_pre;
      div_val <= wr_div;
      loaded  <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_tick_prescaler.sv
module flash_tick_prescaler #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic bypass,
  output logic step
);

  localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == LAST);
  assign step    = run && (bypass || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || bypass) begin
      cnt <= '0;
    end else if (at_last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             wrap
);

  logic [DIV_W-1:0] cnt;

  assign wrap = run && step && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run) begin
      cnt <= '0;
    end else if (step) begin
      if (wrap) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen
  import flash_tick_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 33_000_000,
  parameter int unsigned DIV_W      = 6,
  parameter int unsigned PRE_RATIO  = 8,
  parameter int unsigned MIN_HZ     = 150_000,
  parameter int unsigned MAX_HZ     = 200_000,
  localparam int unsigned CTRL_W    = DIV_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              tick,
  output logic              loaded,
  output logic              cmd_permit,
  output logic              freq_out_of_range
);

  localparam int unsigned PRE_BIT = DIV_W;

  logic             pre_en;
  logic [DIV_W-1:0] div_val;
  logic             pre_tick;   // prescaler stage step
  logic             wrap;       // divider stage terminal count
  logic             restart;    // counters cleared by a write
  u64_t             period;

  assign restart = wr_en;

  flash_tick_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_pre  (wr_data[PRE_BIT]),
    .wr_div  (wr_data[DIV_W-1:0]),
    .pre_en  (pre_en),
    .div_val (div_val),
    .loaded  (loaded)
  );

  flash_tick_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (loaded),
    .bypass  (!pre_en),
    .step    (pre_tick)
  );

  flash_tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (loaded),
    .step    (pre_tick),
    .limit   (div_val),
    .wrap    (wrap)
  );

  assign tick       = wrap;
  assign cmd_permit = loaded;
  assign rd_data    = {loaded, pre_en, div_val};

  always_comb begin
    period = strobe_period(pre_en, 64'(div_val), 64'(PRE_RATIO));
    freq_out_of_range = loaded &&
      outside_window(64'(SYS_CLK_HZ), period, 64'(MIN_HZ), 64'(MAX_HZ));
  end

endmodule

// File: rtl/flash_tick_checker.sv
module flash_tick_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tick,
  input logic       loaded,
  input logic       cmd_permit,
  input logic       freq_out_of_range,
  input logic       pre_tick,
  input logic       wrap
);

  a_r2_write_captured: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[6:0] == $past(wr_data[6:0])) && rd_data[7]);

  a_r3_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);

  a_r3_loaded_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(wr_en));

  a_r4_quiet_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (!tick && !cmd_permit && !freq_out_of_range));

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && (rd_data[6:0] != 7'd0)) |=> !tick);

  a_r5_tick_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> pre_tick);

  a_r7_restart_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[6:0] != 7'd0)) |=> !tick);

endmodule

bind flash_tick_gen flash_tick_checker u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .wr_en             (wr_en),
  .wr_data           (wr_data),
  .rd_data           (rd_data),
  .tick              (tick),
  .loaded            (loaded),
  .cmd_permit        (cmd_permit),
  .freq_out_of_range (freq_out_of_range),
  .pre_tick          (pre_tick),
  .wrap              (wrap)
);

// File: tb/flash_tick_gen_bench.sv
module flash_tick_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 33_000_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick, loaded, cmd_permit, freq_out_of_range;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string tick_tag = "R5";

  // reference model state
  int m_pre = 0, m_div = 0, m_loaded = 0, m_phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_tick_gen u_flash_tick_gen (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .rd_data (rd_data), .tick (tick), .loaded (loaded),
    .cmd_permit (cmd_permit), .freq_out_of_range (freq_out_of_range)
  );

  function automatic int m_period();
    return (m_pre != 0 ? 8 : 1) * (m_div + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_div = 0; m_loaded = 0; m_phase = 0;
    end else if (wr_en) begin
      m_pre = int'(wr_data[6]);
      m_div = int'(wr_data[5:0]);
      m_loaded = 1;
      m_phase = 0;
    end else if (m_loaded != 0) begin
      m_phase = (m_phase + 1) % m_period();
    end
  end

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_cycle();
    int n, f, e_tick, e_oor;
    n = m_period();
    f = SYS_HZ / n;
    e_tick = (m_loaded != 0 && m_phase == n - 1) ? 1 : 0;
    e_oor  = (m_loaded != 0 && (f < 150000 || f > 200000)) ? 1 : 0;
    vectors++;
    cmp(m_loaded != 0 ? "R2" : "R1", "rd_data", int'(rd_data),
        (m_loaded << 7) | (m_pre << 6) | m_div);
    cmp("R3", "loaded", int'(loaded), m_loaded);
    cmp("R4", "cmd_permit", int'(cmd_permit), m_loaded);
    cmp(m_loaded != 0 ? tick_tag : "R4", "tick", int'(tick), e_tick);
    cmp("R8", "freq_out_of_range", int'(freq_out_of_range), e_oor);
  endtask

  always @(negedge clk) if (!done) check_cycle();

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); #2;
    wr_en = 1'b1; wr_data = v;
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    idle(4);
    #2 rst_n = 1'b1;
    idle(20);                       // R1/R4: quiet before first write
    tick_tag = "R5";
    do_write(8'h54); idle(400);     // N = 168, in range
    tick_tag = "R6";
    do_write(8'h00); idle(8);       // tick every cycle
    do_write(8'h03); idle(20);      // N = 4
    do_write(8'h05); idle(20);      // bit 7 written as 0, reads 0x85
    tick_tag = "R7";
    do_write(8'h54); idle(60);
    do_write(8'h54); idle(200);     // rewrite mid-period restarts
    do_write(8'h4F); idle(30);
    do_write(8'h4F); idle(300);
    tick_tag = "R8";
    do_write(8'h14); idle(30);      // no prescale, div 20: too fast
    do_write(8'h5B); idle(20);      // N = 224: too slow
    do_write(8'h5A); idle(20);      // N = 216: in range
    do_write(8'h40); idle(20);      // N = 8: too fast
    do_write(8'hFF); idle(600);     // N = 512: too slow
    @(negedge clk); #2 rst_n = 1'b0; // R1: reset mid-run
    idle(3);
    #2 rst_n = 1'b1;
    idle(20);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R5 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule